// File: doc/BRIEF.md
# Processor Cold-Start Sequencer

This block is the system-side controller that takes a processor from a cold power-up to a running state. It waits until the supplies and system clock are reported stable. It then steps through a fixed timed sequence: it raises DC-ok, loads a 64-bit configuration word into the processor over the address/data bus using a grant strobe, and issues a one-cycle response-valid pulse that aligns the processor's internal clocks. Last, it releases reset. Each wait is a parameter counted in system clock cycles. One shared down-counter times every interval.

Once reset is released, the block keeps mastership of the bus. It ignores the processor's request lines until every processor in the cluster asserts its active-low request. At that point the ready flag goes high and stays high. If the stable indication drops at any moment, the whole sequence restarts from the off state. The configuration word supplied on the input should hold the default clock-divider settings, which are a system divider of 1 and a secondary-cache divider of 3, unless the system overrides them. The word is captured when the mode-load phase begins, so the bus holds a steady value while the grant is active.

Top module: `cold_start_seq`

## Requirements
- R1: While rst_n is low and in the off phase, the outputs are as follows: dc_ok_o=0, sys_reset_n_o=0, sys_gnt_n_o=1, sys_resp_val_n_o=1, bus_oe_o=0, bus_data_o=0, phase_o=0 and ready_o=0.
- R2: phase_o shows the current phase with these codes: 0 off, 1 supply wait, 2 first settle, 3 mode setup, 4 grant, 5 mode tail, 6 second settle, 7 sync pulse, 8 third settle, 9 released/waiting, 10 ready. The first clock edge that sees pwr_stable_i high enters phase 1. dc_ok_o rises exactly T_SUPPLY cycles later and stays high through phase 10.
- R3: After T_SETTLE_A cycles of first settle, the bus is driven. bus_oe_o=1 and bus_data_o shows the mode word captured on the edge that enters phase 3, and later changes of mode_word_i have no effect. The bus holds for T_MODE_SETUP cycles with the grant negated. Then sys_gnt_n_o is low for exactly T_GRANT cycles. The word stays on the bus for one more cycle after the grant negates. After that, bus_oe_o=0 and bus_data_o=0.
- R4: After T_SETTLE_B cycles of second settle, sys_resp_val_n_o is low for exactly one cycle, and at no other time.
- R5: After T_SETTLE_C cycles of third settle, sys_reset_n_o goes high. sys_reset_n_o is never high while dc_ok_o is low.
- R6: After reset is released, the block stays in phase 9 with the bus idle until the request condition is met. Request inputs seen before phase 9 leave the timing of every earlier phase unchanged.
- R7: ready_o rises one cycle after an edge in phase 9 sees all NUM_CPU bits of cpu_req_n_i low. A partial set of requests keeps phase 9. After that, ready_o stays high even if the requests are withdrawn.
- R8: If pwr_stable_i is low at a clock edge in any phase, the next cycle is phase 0 with the outputs of R1 and ready_o=0. Raising pwr_stable_i again replays the full sequence with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| pwr_stable_i | input | 1 | Supplies and system clock reported stable |
| mode_word_i | input | 64 | Configuration word to load into the processor |
| cpu_req_n_i | input | NUM_CPU | Active-low bus request from each processor |
| dc_ok_o | output | 1 | DC-ok to the processor |
| sys_reset_n_o | output | 1 | Active-low processor reset |
| sys_gnt_n_o | output | 1 | Active-low bus grant, strobes the mode load |
| sys_resp_val_n_o | output | 1 | Active-low response-valid, clock-sync pulse |
| bus_oe_o | output | 1 | Bus output enable |
| bus_data_o | output | 64 | Address/data bus value (zero when not driven) |
| phase_o | output | 4 | Current phase code |
| ready_o | output | 1 | All processors have requested the bus |

## Verification
The assertions assume that pwr_stable_i and cpu_req_n_i are synchronous to clk and change only between edges. They also assume that the default interval parameters meet the minimums of two setup cycles and one grant cycle. The bench drives all inputs on the falling edge and uses only the default parameters. It cuts the stable indication at every cycle offset from the first edge through the last cycle of third settle. It sets request lines low both before release and after release, fully and partially, so that the strobe and release checks see only legal input orderings.

// File: rtl/cold_start_pkg.sv
package cold_start_pkg;

  typedef enum logic [3:0] {
    PH_OFF   = 4'd0,
    PH_PWR   = 4'd1,
    PH_SET1  = 4'd2,
    PH_SETUP = 4'd3,
    PH_GNT   = 4'd4,
    PH_TAIL  = 4'd5,
    PH_SET2  = 4'd6,
    PH_SYNC  = 4'd7,
    PH_SET3  = 4'd8,
    PH_REL   = 4'd9,
    PH_READY = 4'd10
  } phase_e;

  // successor of a timed phase in the fixed order
  function automatic phase_e next_timed(phase_e p);
    unique case (p)
      PH_PWR:   return PH_SET1;
      PH_SET1:  return PH_SETUP;
      PH_SETUP: return PH_GNT;
      PH_GNT:   return PH_TAIL;
      PH_TAIL:  return PH_SET2;
      PH_SET2:  return PH_SYNC;
      PH_SYNC:  return PH_SET3;
      PH_SET3:  return PH_REL;
      default:  return p;
    endcase
  endfunction

  function automatic logic is_timed(phase_e p);
    return (p != PH_OFF) && (p != PH_REL) && (p != PH_READY);
  endfunction

  function automatic logic drives_bus(phase_e p);
    return (p == PH_SETUP) || (p == PH_GNT) || (p == PH_TAIL);
  endfunction

endpackage

// File: rtl/seq_dwell_timer.sv
module seq_dwell_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/seq_req_join.sv
module seq_req_join #(
  parameter int NUM_CPU = 2
) (
  input  logic [NUM_CPU-1:0] req_n_i,
  output logic               all_o
);

  logic [NUM_CPU-1:0] seen;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    assign seen[g] = ~req_n_i[g];
  end

  assign all_o = &seen;

endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
  import cold_start_pkg::*;
#(
  parameter int T_SUPPLY     = 12,
  parameter int T_SETTLE_A   = 30,
  parameter int T_MODE_SETUP = 3,
  parameter int T_GRANT      = 2,
  parameter int T_SETTLE_B   = 25,
  parameter int T_SETTLE_C   = 20,
  parameter int CW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stable_i,
  input  logic          all_req_i,
  input  logic          expired_i,
  output phase_e        phase_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          enter_setup_o
);

  phase_e state_q, nxt;

  // cycles spent in each phase; untimed phases count as one
  function automatic int dwell(phase_e p);
    unique case (p)
      PH_PWR:   return T_SUPPLY;
      PH_SET1:  return T_SETTLE_A;
      PH_SETUP: return T_MODE_SETUP;
      PH_GNT:   return T_GRANT;
      PH_SET2:  return T_SETTLE_B;
      PH_SET3:  return T_SETTLE_C;
      default:  return 1;
    endcase
  endfunction

  always_comb begin
    nxt    = state_q;
    load_o = 1'b0;
    if (!stable_i) begin
      nxt    = PH_OFF;
      load_o = (state_q != PH_OFF);
    end else begin
      unique case (state_q)
        PH_OFF: begin
          nxt    = PH_PWR;
          load_o = 1'b1;
        end
        PH_REL: begin
          if (all_req_i) begin
            nxt    = PH_READY;
            load_o = 1'b1;
          end
        end
        PH_READY: nxt = PH_READY;
        default: begin
          if (is_timed(state_q) && expired_i) begin
            nxt    = next_timed(state_q);
            load_o = 1'b1;
          end
        end
      endcase
    end
  end

  assign load_val_o    = CW'(dwell(nxt) - 1);
  assign enter_setup_o = load_o && (nxt == PH_SETUP);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PH_OFF;
    else        state_q <= nxt;
  end

  assign phase_o = state_q;

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stable_i |=> state_q == PH_OFF);

  // R7
  partial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_REL && stable_i && !all_req_i) |=> state_q == PH_REL);

  // R7
  ready_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_READY && stable_i) |=> state_q == PH_READY);

  // R2
  no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_timed(state_q) && !expired_i && stable_i) |=> $stable(state_q));

endmodule

// File: rtl/seq_out_drive.sv
module seq_out_drive
  import cold_start_pkg::*;
#(
  parameter int BUS_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_i,
  input  logic             capture_i,
  input  logic [BUS_W-1:0] mode_i,
  output logic             dc_ok_o,
  output logic             sys_reset_n_o,
  output logic             sys_gnt_n_o,
  output logic             sys_resp_val_n_o,
  output logic             bus_oe_o,
  output logic [BUS_W-1:0] bus_data_o,
  output logic             ready_o
);

  logic [BUS_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= '0;
    else if (capture_i) mode_q <= mode_i;
  end

  assign dc_ok_o          = (phase_i != PH_OFF) && (phase_i != PH_PWR);
  assign sys_reset_n_o    = (phase_i == PH_REL) || (phase_i == PH_READY);
  assign sys_gnt_n_o      = (phase_i != PH_GNT);
  assign sys_resp_val_n_o = (phase_i != PH_SYNC);
  assign bus_oe_o         = drives_bus(phase_i);
  assign bus_data_o       = bus_oe_o ? mode_q : '0;
  assign ready_o          = (phase_i == PH_READY);

  // R3
  gnt_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_gnt_n_o |-> bus_oe_o);

  // R3
  gnt_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sys_gnt_n_o) && phase_i != PH_OFF) |-> bus_oe_o);

  // R3
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_o && $past(bus_oe_o)) |-> $stable(bus_data_o));

  // R3
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> bus_data_o == '0);

  // R4
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_resp_val_n_o |=> sys_resp_val_n_o);

  // R5
  reset_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dc_ok_o |-> !sys_reset_n_o);

  // R7
  ready_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (sys_reset_n_o && dc_ok_o && !bus_oe_o));

endmodule

// File: rtl/cold_start_seq.sv
module cold_start_seq
  import cold_start_pkg::*;
#(
  parameter int NUM_CPU      = 2,
  parameter int BUS_W        = 64,
  parameter int T_SUPPLY     = 12,
  parameter int T_SETTLE_A   = 30,
  parameter int T_MODE_SETUP = 3,
  parameter int T_GRANT      = 2,
  parameter int T_SETTLE_B   = 25,
  parameter int T_SETTLE_C   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_stable_i,
  input  logic [BUS_W-1:0]   mode_word_i,
  input  logic [NUM_CPU-1:0] cpu_req_n_i,
  output logic               dc_ok_o,
  output logic               sys_reset_n_o,
  output logic               sys_gnt_n_o,
  output logic               sys_resp_val_n_o,
  output logic               bus_oe_o,
  output logic [BUS_W-1:0]   bus_data_o,
  output logic [3:0]         phase_o,
  output logic               ready_o
);

  localparam int SPAN = T_SUPPLY + T_SETTLE_A + T_MODE_SETUP + T_GRANT
                      + T_SETTLE_B + T_SETTLE_C;
  localparam int CW   = $clog2(SPAN + 1);

  initial begin
    setup_min_chk: assert (T_MODE_SETUP >= 2);
    grant_min_chk: assert (T_GRANT >= 1);
  end

  phase_e          phase;
  logic            all_req;
  logic            expired;
  logic            load;
  logic [CW-1:0]   load_val;
  logic            enter_setup;

  seq_req_join #(.NUM_CPU(NUM_CPU)) u_join (
    .req_n_i (cpu_req_n_i),
    .all_o   (all_req)
  );

  seq_dwell_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  seq_phase_fsm #(
    .T_SUPPLY     (T_SUPPLY),
    .T_SETTLE_A   (T_SETTLE_A),
    .T_MODE_SETUP (T_MODE_SETUP),
    .T_GRANT      (T_GRANT),
    .T_SETTLE_B   (T_SETTLE_B),
    .T_SETTLE_C   (T_SETTLE_C),
    .CW           (CW)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .stable_i      (pwr_stable_i),
    .all_req_i     (all_req),
    .expired_i     (expired),
    .phase_o       (phase),
    .load_o        (load),
    .load_val_o    (load_val),
    .enter_setup_o (enter_setup)
  );

  seq_out_drive #(.BUS_W(BUS_W)) u_out (
    .clk              (clk),
    .rst_n            (rst_n),
    .phase_i          (phase),
    .capture_i        (enter_setup),
    .mode_i           (mode_word_i),
    .dc_ok_o          (dc_ok_o),
    .sys_reset_n_o    (sys_reset_n_o),
    .sys_gnt_n_o      (sys_gnt_n_o),
    .sys_resp_val_n_o (sys_resp_val_n_o),
    .bus_oe_o         (bus_oe_o),
    .bus_data_o       (bus_data_o),
    .ready_o          (ready_o)
  );

  assign phase_o = phase;

  // R5
  release_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset_n_o) |-> $past(phase) == PH_SET3);

endmodule

// File: tb/cold_start_seq_tb.sv
module cold_start_seq_tb;

  localparam int NC = 2;
  localparam int TS = 12, TA = 30, TM = 3, TG = 2, TB = 25, TC = 20;
  localparam int REL_E = TS + TA + TM + TG + 1 + TB + 1 + TC + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stable;
  logic [63:0]   mode_word;
  logic [NC-1:0] req_n;
  logic          dc_ok, reset_n, gnt_n, resp_n, oe, ready;
  logic [63:0]   data;
  logic [3:0]    phase;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cold_start_seq #(
    .NUM_CPU(NC), .BUS_W(64), .T_SUPPLY(TS), .T_SETTLE_A(TA),
    .T_MODE_SETUP(TM), .T_GRANT(TG), .T_SETTLE_B(TB), .T_SETTLE_C(TC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_stable_i(stable), .mode_word_i(mode_word),
    .cpu_req_n_i(req_n), .dc_ok_o(dc_ok), .sys_reset_n_o(reset_n),
    .sys_gnt_n_o(gnt_n), .sys_resp_val_n_o(resp_n), .bus_oe_o(oe),
    .bus_data_o(data), .phase_o(phase), .ready_o(ready)
  );

  // expected phase e edges after pwr_stable was raised in the off phase
  function automatic int exp_phase(int e);
    int durs [8];
    int rem;
    durs = '{TS, TA, TM, TG, 1, TB, 1, TC};
    if (e <= 0) return 0;
    rem = e;
    for (int i = 0; i < 8; i++) begin
      if (rem <= durs[i]) return i + 1;
      rem -= durs[i];
    end
    return 9;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input int ph, input logic [63:0] m, input string req);
    logic ex_oe;
    ex_oe = (ph >= 3) && (ph <= 5);
    chk(req,  "phase",   64'(phase),   64'(ph));
    chk("R2", "dc_ok",   64'(dc_ok),   64'(ph >= 2));
    chk("R5", "reset_n", 64'(reset_n), 64'(ph >= 9));
    chk("R3", "gnt_n",   64'(gnt_n),   64'(ph != 4));
    chk("R4", "resp_n",  64'(resp_n),  64'(ph != 7));
    chk("R3", "bus_oe",  64'(oe),      64'(ex_oe));
    chk("R3", "bus_data", data, ex_oe ? m : 64'h0);
    chk("R7", "ready",   64'(ready),   64'(ph == 10));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] mv;
    rst_n = 1'b0; stable = 1'b0; mode_word = '0; req_n = '1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_out(0, 64'h0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin step(); check_out(0, 64'h0, "R8"); end

    // full run, requests withdrawn until after release
    mv = 64'hA5A5_0F0F_1234_5678;
    mode_word = mv;
    stable = 1'b1;
    for (int e = 1; e <= REL_E; e++) begin
      step();
      check_out(exp_phase(e), mv, "R2");
      if (exp_phase(e) == 3) mode_word = ~mv;  // R3 capture, later value ignored
    end
    for (int i = 0; i < 10; i++) begin step(); check_out(9, mv, "R6"); end
    req_n = 2'b10;
    for (int i = 0; i < 4; i++) begin step(); check_out(9, mv, "R7"); end
    req_n = 2'b00;
    step(); check_out(10, mv, "R7");
    req_n = 2'b11;
    for (int i = 0; i < 3; i++) begin step(); check_out(10, mv, "R7"); end
    stable = 1'b0;
    step(); check_out(0, mv, "R8");

    // early requests: timing unchanged, ready right after release
    req_n = 2'b00;
    mv = 64'h0123_4567_89AB_CDEF;
    mode_word = mv;
    stable = 1'b1;
    for (int e = 1; e <= REL_E; e++) begin
      step();
      check_out(exp_phase(e), mv, "R6");
    end
    step(); check_out(10, mv, "R7");
    stable = 1'b0;
    step(); check_out(0, mv, "R8");

    // abort sweep over every cycle offset of the timed sequence
    req_n = 2'b11;
    for (int ab = 1; ab < REL_E; ab++) begin
      mv = 64'hDEAD_BEEF_0000_0000 ^ 64'(ab * 7919);
      mode_word = mv;
      stable = 1'b1;
      for (int e = 1; e <= ab; e++) begin
        step();
        check_out(exp_phase(e), mv, "R4");
      end
      stable = 1'b0;
      step(); check_out(0, mv, "R8");
      step(); check_out(0, mv, "R1");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule